// File: doc/BRIEF.md
# Receive Endpoint Control and Status Register

This block holds the eight-bit control and status byte of one USB receive endpoint, together with the sequencing that the byte drives. Software writes and reads the byte over a plain byte-wide port. The receive path reports each finished packet with its length, a PID error flag and a flag for a high-bandwidth packet that lost data. The unload side reports CPU byte reads and DMA word reads from the receive FIFO.

From these events the block keeps a packet-ready flag and a request-packet flag, raises a DMA request, and holds the endpoint data toggle. When a full-size packet has been drained, it can drop packet-ready by itself. Once packet-ready has dropped, it can ask for the next packet by itself. Changes to the toggle are gated by a write-enable bit that disarms after one use.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset every register bit reads 0, and `pkt_rdy`, `req_pkt`, `dma_req` and `data_tgl` are all 0.
- R2: `reg_rdata` bit positions are as follows. Bit 7 is auto-clear enable, bit 6 auto-request enable, bit 5 DMA enable and bit 4 PID error. Bit 3 is DMA mode, bit 2 toggle write arm, bit 1 data toggle and bit 0 incomplete status. A write loads bits 7, 6, 5 and 3 directly.
- R3: With bit 7 set and a received length equal to `max_pkt`, `pkt_rdy` drops on the clock edge where the unloaded count reaches at least `max_pkt`. A `cpu_rd` adds 1 to the count and a `dma_rd` adds 4. With bit 7 clear, or for a shorter packet, `pkt_rdy` stays 1 after unloading.
- R4: `rx_done` sets `pkt_rdy` on the next edge. A `sw_rdy_clr` pulse clears it on the next edge. The unloaded count restarts at 0 whenever `pkt_rdy` is 0.
- R5: With bit 6 set, `req_pkt` rises one cycle after the edge on which `pkt_rdy` falls. It is not set when bit 6 is clear, and `rx_done` clears it.
- R6: A packet with `rx_len` < `max_pkt` clears bit 6 by hardware.
- R7: A write changes bit 1 only if bit 2 was already 1 before that write. Such a write also clears bit 2. A write made while bit 2 is 0 loads bit 2 from the data and leaves bit 1 unchanged.
- R8: Bit 1 and `data_tgl` show the endpoint toggle, which inverts on each `rx_done`.
- R9: Bit 4 is loaded from `rx_pid_err` on each `rx_done`. Register writes do not change it.
- R10: Bit 0 is set on `rx_done` with `rx_incomp`. Writing 0 to bit 0 clears it, and writing 1 to it has no effect.
- R11: `dma_req` is 1 only while bit 5 and `pkt_rdy` are both 1. With bit 3 = 0 it holds for the whole time `pkt_rdy` is 1. With bit 3 = 1 it also needs at least 4 unread bytes of the current packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| max_pkt | input | MAXP_W | Maximum packet size in bytes |
| rx_done | input | 1 | Packet received pulse |
| rx_len | input | MAXP_W | Byte count of received packet |
| rx_pid_err | input | 1 | Received packet had a PID error |
| rx_incomp | input | 1 | High-bandwidth packet missing data |
| sw_rdy_clr | input | 1 | Software clear of packet-ready |
| cpu_rd | input | 1 | One byte unloaded by CPU |
| dma_rd | input | 1 | Four bytes unloaded by DMA |
| pkt_rdy | output | 1 | Packet waiting in FIFO |
| req_pkt | output | 1 | Request next packet |
| dma_req | output | 1 | DMA service request |
| data_tgl | output | 1 | Endpoint data toggle |

## Verification
The properties are checked on every cycle. They cover the gating of the DMA request, the request flag that follows a fall of packet-ready, the toggle holding during unarmed writes, the arm bit disarming after use, the PID bit being read-only, and the clearing of auto-request on a short packet. Only the bench scenarios can show the exact unload edge on which packet-ready drops for CPU and DMA counting. The same applies to the mode 1 cutoff when fewer than four bytes remain, to the clearing of incomplete status by a written zero, and to the absence of any automatic clearing for short packets or with auto-clear disabled.

// File: rtl/usb_rxep_pkg.sv
package usb_rxep_pkg;

  // Field order matches the register bit positions, MSB first.
  typedef struct packed {
    logic auto_clr;
    logic auto_req;
    logic dma_en;
    logic pid_err;
    logic dma_mode;
    logic tgl_we;
    logic tgl;
    logic incomp;
  } rxep_csr_t;

  localparam int unsigned DMA_CHUNK = 4;

endpackage

// File: rtl/rxep_csr.sv
module rxep_csr
  import usb_rxep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wdata,
  input  logic      rx_done,
  input  logic      rx_short,
  input  logic      rx_pid_err,
  input  logic      rx_incomp,
  output rxep_csr_t csr_q
);

  rxep_csr_t csr_d;
  rxep_csr_t wr_v;
  logic      csr_en;
  logic      sw_tgl_upd;

  assign wr_v       = rxep_csr_t'(wdata);
  assign sw_tgl_upd = wr_en & csr_q.tgl_we;
  assign csr_en     = wr_en | rx_done;

  always_comb begin
    csr_d = csr_q;
    if (wr_en) begin
      csr_d.auto_clr = wr_v.auto_clr;
      csr_d.auto_req = wr_v.auto_req;
      csr_d.dma_en   = wr_v.dma_en;
      csr_d.dma_mode = wr_v.dma_mode;
      if (csr_q.tgl_we) begin
        csr_d.tgl    = wr_v.tgl;
        csr_d.tgl_we = 1'b0;
      end else begin
        csr_d.tgl_we = wr_v.tgl_we;
      end
      if (!wr_v.incomp) csr_d.incomp = 1'b0;
    end
    if (rx_done) begin
      if (!sw_tgl_upd) csr_d.tgl = ~csr_q.tgl;
      csr_d.pid_err = rx_pid_err;
      if (rx_incomp) csr_d.incomp   = 1'b1;
      if (rx_short)  csr_d.auto_req = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q <= '0;
    else if (csr_en) csr_q <= csr_d;
  end

endmodule

// File: rtl/rxep_unload.sv
module rxep_unload
  import usb_rxep_pkg::*;
#(
  parameter int unsigned MAXP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_rdy,
  input  logic              rx_done,
  input  logic [MAXP_W-1:0] rx_len,
  input  logic [MAXP_W-1:0] max_pkt,
  input  logic              cpu_rd,
  input  logic              dma_rd,
  input  logic              sw_clr,
  input  logic              auto_clr,
  input  logic              dma_en,
  input  logic              dma_mode,
  output logic              full_hit,
  output logic              dma_req
);

  localparam int unsigned CNT_W = MAXP_W + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d, step, sum, rem, len_x, max_x;
  logic [MAXP_W-1:0] len_q;
  logic              cnt_en, cnt_zero;

  assign len_x = {1'b0, len_q};
  assign max_x = {1'b0, max_pkt};
  assign step  = CNT_W'(cpu_rd) + (dma_rd ? CNT_W'(DMA_CHUNK) : '0);
  assign sum   = cnt_q + step;

  assign full_hit = pkt_rdy & auto_clr & (len_q == max_pkt)
                  & (cpu_rd | dma_rd) & (sum >= max_x);

  assign cnt_zero = rx_done | ~pkt_rdy | full_hit | sw_clr;
  assign cnt_en   = cnt_zero | cpu_rd | dma_rd;
  assign cnt_d    = cnt_zero ? '0 : sum;

  assign rem = (cnt_q >= len_x) ? '0 : (len_x - cnt_q);

  assign dma_req = pkt_rdy & dma_en & (~dma_mode | (rem >= CNT_W'(DMA_CHUNK)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (rx_done) len_q <= rx_len;
  end

endmodule

// File: rtl/rxep_flow.sv
module rxep_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_done,
  input  logic sw_clr,
  input  logic full_hit,
  input  logic auto_req,
  output logic pkt_rdy,
  output logic req_pkt
);

  logic rdy_q, rdy_d, prev_q, req_q, req_d, fell;

  assign rdy_d = rx_done | (rdy_q & ~sw_clr & ~full_hit);
  assign fell  = prev_q & ~rdy_q;
  assign req_d = ~rx_done & (req_q | (fell & auto_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      rdy_q  <= rdy_d;
      prev_q <= rdy_q;
      req_q  <= req_d;
    end
  end

  assign pkt_rdy = rdy_q;
  assign req_pkt = req_q;

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rxep_pkg::*;
#(
  parameter int unsigned MAXP_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [MAXP_W-1:0] max_pkt,
  input  logic              rx_done,
  input  logic [MAXP_W-1:0] rx_len,
  input  logic              rx_pid_err,
  input  logic              rx_incomp,
  input  logic              sw_rdy_clr,
  input  logic              cpu_rd,
  input  logic              dma_rd,
  output logic              pkt_rdy,
  output logic              req_pkt,
  output logic              dma_req,
  output logic              data_tgl
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  rxep_csr_t  csr;
  logic       full_hit;
  logic       rx_short;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign rx_short = rx_len < max_pkt;

  rxep_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (reg_wr_en),
    .wdata      (reg_wdata),
    .rx_done    (rx_done),
    .rx_short   (rx_short),
    .rx_pid_err (rx_pid_err),
    .rx_incomp  (rx_incomp),
    .csr_q      (csr)
  );

  rxep_unload #(.MAXP_W(MAXP_W)) u_unload (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pkt_rdy  (pkt_rdy),
    .rx_done  (rx_done),
    .rx_len   (rx_len),
    .max_pkt  (max_pkt),
    .cpu_rd   (cpu_rd),
    .dma_rd   (dma_rd),
    .sw_clr   (sw_rdy_clr),
    .auto_clr (csr.auto_clr),
    .dma_en   (csr.dma_en),
    .dma_mode (csr.dma_mode),
    .full_hit (full_hit),
    .dma_req  (dma_req)
  );

  rxep_flow u_flow (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rx_done  (rx_done),
    .sw_clr   (sw_rdy_clr),
    .full_hit (full_hit),
    .auto_req (csr.auto_req),
    .pkt_rdy  (pkt_rdy),
    .req_pkt  (req_pkt)
  );

  assign reg_rdata = csr;
  assign data_tgl  = csr.tgl;

endmodule

// File: rtl/rxep_ctrl_chk.sv
module rxep_ctrl_chk #(
  parameter int unsigned MAXP_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [7:0]        reg_rdata,
  input logic              rx_done,
  input logic [MAXP_W-1:0] rx_len,
  input logic [MAXP_W-1:0] max_pkt,
  input logic              pkt_rdy,
  input logic              req_pkt,
  input logic              dma_req,
  input logic              data_tgl
);

  p_dma_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (pkt_rdy && reg_rdata[5]));

  p_req_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pkt_rdy) && reg_rdata[6] && !rx_done) |=> req_pkt);

  p_rdy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> pkt_rdy);

  p_tgl_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_rdata[2] && !rx_done) |=> $stable(data_tgl));

  p_arm_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_rdata[2]) |=> !reg_rdata[2]);

  p_pid_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(reg_rdata[4]));

  p_short_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && (rx_len < max_pkt)) |=> !reg_rdata[6]);

endmodule

bind usb_rx_ep_ctrl rxep_ctrl_chk #(.MAXP_W(MAXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr_en (reg_wr_en),
  .reg_rdata (reg_rdata),
  .rx_done   (rx_done),
  .rx_len    (rx_len),
  .max_pkt   (max_pkt),
  .pkt_rdy   (pkt_rdy),
  .req_pkt   (req_pkt),
  .dma_req   (dma_req),
  .data_tgl  (data_tgl)
);

// File: tb/tb_usb_rx_ep_ctrl.sv
`timescale 1ns/1ps
module tb_usb_rx_ep_ctrl;

  localparam int unsigned MAXP_W = 11;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr_en, rx_done, rx_pid_err, rx_incomp;
  logic              sw_rdy_clr, cpu_rd, dma_rd;
  logic [7:0]        reg_wdata, reg_rdata;
  logic [MAXP_W-1:0] max_pkt, rx_len;
  logic              pkt_rdy, req_pkt, dma_req, data_tgl;

  always #2.5 clk = ~clk;

  usb_rx_ep_ctrl #(.MAXP_W(MAXP_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .max_pkt(max_pkt), .rx_done(rx_done),
    .rx_len(rx_len), .rx_pid_err(rx_pid_err), .rx_incomp(rx_incomp),
    .sw_rdy_clr(sw_rdy_clr), .cpu_rd(cpu_rd), .dma_rd(dma_rd),
    .pkt_rdy(pkt_rdy), .req_pkt(req_pkt), .dma_req(dma_req), .data_tgl(data_tgl)
  );

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic [3:0] fl;   // {pkt_rdy, req_pkt, dma_req, data_tgl}
  } exp_t;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  // Monitor: compares the design against each queued item after its edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic [3:0] act;
      e   = q.pop_front();
      act = {pkt_rdy, req_pkt, dma_req, data_tgl};
      n_run++;
      if (reg_rdata !== e.rd || act !== e.fl) begin
        n_fail++;
        $display("FAIL %s: rdata=%h flags=%b expected rdata=%h flags=%b",
                 e.tag, reg_rdata, act, e.rd, e.fl);
      end
    end
  end

  // Driver: inputs are set at a negedge, then the item is queued at the edge.
  task automatic step(input string tag, input logic [7:0] rd, input logic [3:0] fl);
    @(posedge clk);
    q.push_back('{tag, rd, fl});
    @(negedge clk);
    reg_wr_en  = 1'b0;
    rx_done    = 1'b0;
    rx_pid_err = 1'b0;
    rx_incomp  = 1'b0;
    sw_rdy_clr = 1'b0;
    cpu_rd     = 1'b0;
    dma_rd     = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v, input string tag, input logic [7:0] rd, input logic [3:0] fl);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    step(tag, rd, fl);
  endtask

  task automatic pkt(input int len, input logic pe, input logic inc, input string tag,
                     input logic [7:0] rd, input logic [3:0] fl);
    rx_done    = 1'b1;
    rx_len     = MAXP_W'(len);
    rx_pid_err = pe;
    rx_incomp  = inc;
    step(tag, rd, fl);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0; rx_done = 1'b0;
    rx_len = '0; rx_pid_err = 1'b0; rx_incomp = 1'b0; sw_rdy_clr = 1'b0;
    cpu_rd = 1'b0; dma_rd = 1'b0; max_pkt = MAXP_W'(8);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step("R1 reset state", 8'h00, 4'b0000);

    // Toggle gating
    wr(8'h02, "R7 toggle write without arm ignored", 8'h00, 4'b0000);
    wr(8'h06, "R7 arm loads, toggle held", 8'h04, 4'b0000);
    wr(8'h02, "R7 armed toggle write, arm drops", 8'h02, 4'b0001);
    wr(8'h11, "R9 R10 pid and incomplete writes ignored", 8'h02, 4'b0001);
    wr(8'hE0, "R2 control fields load", 8'hE2, 4'b0001);

    // Full-size packet with CPU unload and auto-clear
    pkt(8, 1'b0, 1'b0, "R8 R4 packet sets ready, toggle flips", 8'hE0, 4'b1010);
    for (int i = 0; i < 7; i++) begin
      cpu_rd = 1'b1;
      step("R3 partial cpu unload keeps ready", 8'hE0, 4'b1010);
    end
    cpu_rd = 1'b1;
    step("R3 eighth byte auto-clears ready", 8'hE0, 4'b0000);
    step("R5 request one cycle after fall", 8'hE0, 4'b0100);

    // Packet with error flags, DMA mode 1
    pkt(8, 1'b1, 1'b1, "R9 R10 R5 error flags latched, request cleared", 8'hF3, 4'b1011);
    wr(8'hE1, "R10 write one keeps incomplete", 8'hF3, 4'b1011);
    wr(8'hE8, "R10 R9 write zero clears incomplete, pid held", 8'hFA, 4'b1011);
    dma_rd = 1'b1;
    step("R11 mode1 four bytes left keeps request", 8'hFA, 4'b1011);
    dma_rd = 1'b1;
    step("R3 second dma word auto-clears", 8'hFA, 4'b0001);
    step("R5 request after dma drain", 8'hFA, 4'b0101);

    // Short packet
    pkt(6, 1'b0, 1'b0, "R6 short packet drops auto-request", 8'hA8, 4'b1010);
    dma_rd = 1'b1;
    step("R11 mode1 two bytes left drops request", 8'hA8, 4'b1000);
    cpu_rd = 1'b1;
    step("R3 short packet not auto-cleared", 8'hA8, 4'b1000);
    cpu_rd = 1'b1;
    step("R3 short packet fully read stays ready", 8'hA8, 4'b1000);
    sw_rdy_clr = 1'b1;
    step("R4 software clear", 8'hA8, 4'b0000);
    step("R5 no request with auto-request off", 8'hA8, 4'b0000);

    // Toggle re-arm and DMA disabled / auto-clear disabled
    wr(8'h04, "R7 re-arm", 8'h04, 4'b0000);
    wr(8'h06, "R7 armed write sets toggle", 8'h02, 4'b0001);
    wr(8'h00, "R7 disarmed write ignored", 8'h02, 4'b0001);
    pkt(8, 1'b0, 1'b0, "R11 dma disabled no request", 8'h00, 4'b1000);
    for (int i = 0; i < 8; i++) begin
      cpu_rd = 1'b1;
      step("R3 no auto-clear when disabled", 8'h00, 4'b1000);
    end
    sw_rdy_clr = 1'b1;
    step("R4 software clear after full read", 8'h00, 4'b0000);
    step("R1 idle settle", 8'h00, 4'b0000);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule